// File: doc/BRIEF.md
# Pipeline Interlock Stall Controller

This block detects read-after-write hazards in a five-stage in-order pipeline (Fetch, Decode, Compute, Memory, Write Back) that has no operand forwarding. The instruction waiting in Decode presents its two source register numbers, each with a use flag, and its destination register number with a write flag. The controller keeps its own record of the destination number and write flag of every older instruction still in flight. A source that matches one of those records is a hazard.

While a hazard exists the controller stops the program counter, makes the Fetch/Decode buffer keep its contents, and forces no-operation control settings into the Decode/Compute buffer. The producing instruction moves on, and each forced bubble moves down behind it. The consumer is released once the producer is no longer tracked. With the default settings the producer is tracked through Compute, Memory and Write Back. A consumer placed directly after its producer is therefore held for three cycles. A parameter removes the Write Back check for a register file that writes in the first half of a cycle and reads in the second.

Top module: `hzd_interlock_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `stall` is 0, `pc_we` is 1, `ifid_hold` is 0 and `idex_bubble` is 0.
- R2: When `dec_valid` is 1, a source with its use flag set that equals the destination of a writing instruction tracked in Compute, Memory or Write Back drives `stall` to 1 in the same cycle.
- R3: With the Write Back check enabled (the default), a consumer that directly follows its producer is stalled for exactly 3 cycles and is then accepted. This holds for each link of a dependency chain.
- R4: With one, two or three independent instructions between the producer and the consumer, the stall lasts 2, 1 or 0 cycles.
- R5: Register 0 never causes a hazard, as a source or as a destination.
- R6: A tracked instruction whose write flag is 0 never causes a hazard, and a source whose use flag is 0 is never compared.
- R7: In every stall cycle `pc_we` is 0, `ifid_hold` is 1 and `idex_bubble` is 1. In every other cycle the three are 1, 0 and 0. An instruction that enters Compute after a stall cycle carries no register write.
- R8: When both sources depend on tracked producers, the stall length is set by the youngest matching producer.
- R9: No run of consecutive stall cycles is longer than the number of tracked stages (3 by default).
- R10: An empty Decode slot (`dec_valid` = 0) never stalls and enters Compute as an instruction that writes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode holds a real instruction |
| dec_rs1 | input | AW | First source register number |
| dec_rs1_en | input | 1 | First source is read |
| dec_rs2 | input | AW | Second source register number |
| dec_rs2_en | input | 1 | Second source is read |
| dec_rd | input | AW | Destination register number |
| dec_rd_en | input | 1 | Instruction writes its destination |
| stall | output | 1 | Hazard present this cycle |
| pc_we | output | 1 | Program counter may update |
| ifid_hold | output | 1 | Fetch/Decode buffer keeps its contents |
| idex_bubble | output | 1 | Decode/Compute buffer gets no-operation settings |

## Verification
The consumer is placed at distances one to four behind its producer. This separates the three tracked stages from one another and from an untracked producer. Dependencies through each source alone and through both sources at once, with producers at different distances, show whether the youngest match sets the stall length. Producers that target register 0, that do not write, and sources whose use flag is clear are tried against the same register numbers that do stall, so a missing qualifier is seen as a spurious stall. An empty Decode slot placed between a producer and its consumer shows both that an empty slot does not stall and that it enters the pipeline as a non-writing entry.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  // Positions of the tracked stages in the tag record
  typedef enum int {
    STG_CMP = 0,
    STG_MEM = 1,
    STG_WB  = 2
  } hzd_stage_e;

  // Tracked depth: Compute and Memory always, Write Back only when the
  // register file cannot write and read the same register in one cycle
  function automatic int track_depth(input bit wb_check);
    return wb_check ? 3 : 2;
  endfunction
endpackage

// File: rtl/hzd_tag_pipe.sv
module hzd_tag_pipe #(
  parameter int AW    = 5,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ins_wr,
  input  logic [AW-1:0] ins_id,
  output logic          tag_wr [DEPTH],
  output logic [AW-1:0] tag_id [DEPTH]
);
  // Stage 0 follows Compute; later stages shift one per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      tag_wr[0] <= 1'b0;
      tag_id[0] <= '0;
    end else begin
      tag_wr[0] <= ins_wr;
      tag_id[0] <= ins_id;
    end
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        tag_wr[s] <= 1'b0;
        tag_id[s] <= '0;
      end else begin
        tag_wr[s] <= tag_wr[s-1];
        tag_id[s] <= tag_id[s-1];
      end
    end
  end
endmodule

// File: rtl/hzd_src_match.sv
module hzd_src_match #(
  parameter int AW    = 5,
  parameter int DEPTH = 3
) (
  input  logic          src_en,
  input  logic [AW-1:0] src_id,
  input  logic          tag_wr [DEPTH],
  input  logic [AW-1:0] tag_id [DEPTH],
  output logic          hit
);
  logic [DEPTH-1:0] stage_hit;

  for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
    assign stage_hit[s] = tag_wr[s] && (tag_id[s] == src_id);
  end

  // Register 0 never carries a dependency
  assign hit = src_en && (src_id != '0) && (|stage_hit);
endmodule

// File: rtl/hzd_interlock_ctrl.sv
module hzd_interlock_ctrl #(
  parameter int AW       = 5,
  parameter bit WB_CHECK = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_valid,
  input  logic [AW-1:0] dec_rs1,
  input  logic          dec_rs1_en,
  input  logic [AW-1:0] dec_rs2,
  input  logic          dec_rs2_en,
  input  logic [AW-1:0] dec_rd,
  input  logic          dec_rd_en,
  output logic          stall,
  output logic          pc_we,
  output logic          ifid_hold,
  output logic          idex_bubble
);
  localparam int TRACK_DEPTH = hzd_pkg::track_depth(WB_CHECK);

  logic          tag_wr [TRACK_DEPTH];
  logic [AW-1:0] tag_id [TRACK_DEPTH];
  logic          hit_a;
  logic          hit_b;
  logic          ins_wr;

  hzd_src_match #(.AW(AW), .DEPTH(TRACK_DEPTH)) u_match_a (
    .src_en (dec_rs1_en),
    .src_id (dec_rs1),
    .tag_wr (tag_wr),
    .tag_id (tag_id),
    .hit    (hit_a)
  );

  hzd_src_match #(.AW(AW), .DEPTH(TRACK_DEPTH)) u_match_b (
    .src_en (dec_rs2_en),
    .src_id (dec_rs2),
    .tag_wr (tag_wr),
    .tag_id (tag_id),
    .hit    (hit_b)
  );

  assign stall = dec_valid && (hit_a || hit_b);

  // A bubble, an empty slot or a write to register 0 enters as non-writing
  assign ins_wr = dec_valid && !stall && dec_rd_en && (dec_rd != '0);

  hzd_tag_pipe #(.AW(AW), .DEPTH(TRACK_DEPTH)) u_tags (
    .clk    (clk),
    .rst    (rst),
    .ins_wr (ins_wr),
    .ins_id (dec_rd),
    .tag_wr (tag_wr),
    .tag_id (tag_id)
  );

  assign pc_we       = !stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;
endmodule

// File: rtl/hzd_interlock_chk.sv
module hzd_interlock_chk #(
  parameter int AW    = 5,
  parameter int DEPTH = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          dec_valid,
  input logic [AW-1:0] dec_rs1,
  input logic          dec_rs1_en,
  input logic [AW-1:0] dec_rs2,
  input logic          dec_rs2_en,
  input logic          stall,
  input logic          cmp_wr
);
  localparam int RW = $clog2(DEPTH + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if (stall && run_q < RW'(DEPTH + 1)) run_q <= run_q + 1'b1;
    else if (!stall) run_q <= '0;
  end

  AST_RESET_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !stall); // R1

  AST_BUBBLE_ENTERS: assert property (@(posedge clk) disable iff (rst)
    stall |=> !cmp_wr); // R7

  AST_ZERO_SOURCES: assert property (@(posedge clk) disable iff (rst)
    ((!dec_rs1_en || dec_rs1 == '0) && (!dec_rs2_en || dec_rs2 == '0)) |-> !stall); // R5

  AST_EMPTY_SLOT: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> (!stall ##1 !cmp_wr)); // R10

  AST_STALL_BOUND: assert property (@(posedge clk) disable iff (rst)
    stall |-> (run_q < RW'(DEPTH))); // R9
endmodule

bind hzd_interlock_ctrl hzd_interlock_chk #(.AW(AW), .DEPTH(TRACK_DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dec_valid  (dec_valid),
  .dec_rs1    (dec_rs1),
  .dec_rs1_en (dec_rs1_en),
  .dec_rs2    (dec_rs2),
  .dec_rs2_en (dec_rs2_en),
  .stall      (stall),
  .cmp_wr     (tag_wr[0])
);

// File: tb/sim_hzd_interlock_ctrl.sv
`timescale 1ns/1ps
module sim_hzd_interlock_ctrl;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dec_valid = 1'b0;
  logic [AW-1:0] dec_rs1 = '0;
  logic          dec_rs1_en = 1'b0;
  logic [AW-1:0] dec_rs2 = '0;
  logic          dec_rs2_en = 1'b0;
  logic [AW-1:0] dec_rd = '0;
  logic          dec_rd_en = 1'b0;
  logic          stall, pc_we, ifid_hold, idex_bubble;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hzd_interlock_ctrl #(.AW(AW), .WB_CHECK(1'b1)) u0 (
    .clk(clk), .rst(rst), .dec_valid(dec_valid),
    .dec_rs1(dec_rs1), .dec_rs1_en(dec_rs1_en),
    .dec_rs2(dec_rs2), .dec_rs2_en(dec_rs2_en),
    .dec_rd(dec_rd), .dec_rd_en(dec_rd_en),
    .stall(stall), .pc_we(pc_we), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Present one instruction in Decode at a negedge and count its stall cycles
  task automatic issue(input bit v, input int a, input bit ae, input int b, input bit be,
                       input int d, input bit de, output int n, output bit sig_ok);
    bit done = 1'b0;
    dec_valid = v; dec_rs1 = AW'(a); dec_rs1_en = ae;
    dec_rs2 = AW'(b); dec_rs2_en = be; dec_rd = AW'(d); dec_rd_en = de;
    n = 0; sig_ok = 1'b1;
    while (!done && n < 10) begin
      #1;
      if (!stall) begin
        if (!(pc_we && !ifid_hold && !idex_bubble)) sig_ok = 1'b0;
        done = 1'b1;
      end else begin
        if (!(!pc_we && ifid_hold && idex_bubble)) sig_ok = 1'b0;
        n++;
      end
      @(negedge clk);
    end
  endtask

  task automatic nop(output int n);
    bit ok;
    issue(1'b1, 0, 1'b0, 0, 1'b0, 0, 1'b0, n, ok);
  endtask

  task automatic drain();
    int n;
    for (int i = 0; i < 4; i++) nop(n);
  endtask

  task automatic t_reset();
    #1;
    chk(!stall && pc_we && !ifid_hold && !idex_bubble, "R1 reset outputs",
        {stall, pc_we, ifid_hold, idex_bubble}, 4'b0100);
    @(negedge clk);
  endtask

  task automatic t_adjacent();
    int n; bit ok;
    issue(1'b1, 0, 1'b0, 0, 1'b0, 5, 1'b1, n, ok);
    issue(1'b1, 5, 1'b1, 1, 1'b1, 6, 1'b1, n, ok);
    chk(n == 3, "R3 adjacent stall length", n, 3);
    chk(ok, "R7 control outputs during stall", ok, 1);
    chk(n > 0, "R2 hazard in Compute stalls", n, 1);
    drain();
  endtask

  task automatic t_distance(input int gap, input int exp);
    int n; bit ok;
    issue(1'b1, 0, 1'b0, 0, 1'b0, 9, 1'b1, n, ok);
    for (int i = 0; i < gap; i++) nop(n);
    issue(1'b1, 0, 1'b0, 9, 1'b1, 4, 1'b1, n, ok);
    chk(n == exp, "R4 stall length by distance", n, exp);
    chk(ok, "R7 control outputs by distance", ok, 1);
    drain();
  endtask

  task automatic t_two_sources();
    int n; bit ok;
    issue(1'b1, 0, 1'b0, 0, 1'b0, 7, 1'b1, n, ok);
    issue(1'b1, 0, 1'b0, 0, 1'b0, 8, 1'b1, n, ok);
    issue(1'b1, 7, 1'b1, 2, 1'b0, 3, 1'b1, n, ok);
    chk(n == 2, "R2 older producer via first source", n, 2);
    drain();
    issue(1'b1, 0, 1'b0, 0, 1'b0, 7, 1'b1, n, ok);
    issue(1'b1, 0, 1'b0, 0, 1'b0, 8, 1'b1, n, ok);
    issue(1'b1, 7, 1'b1, 8, 1'b1, 3, 1'b1, n, ok);
    chk(n == 3, "R8 youngest producer sets length", n, 3);
    drain();
  endtask

  task automatic t_reg_zero();
    int n; bit ok;
    issue(1'b1, 0, 1'b0, 0, 1'b0, 0, 1'b1, n, ok);
    issue(1'b1, 0, 1'b1, 0, 1'b1, 2, 1'b1, n, ok);
    chk(n == 0, "R5 register 0 no hazard", n, 0);
    drain();
  endtask

  task automatic t_no_write();
    int n; bit ok;
    issue(1'b1, 0, 1'b0, 0, 1'b0, 9, 1'b0, n, ok);
    issue(1'b1, 9, 1'b1, 9, 1'b1, 2, 1'b1, n, ok);
    chk(n == 0, "R6 non-writing producer", n, 0);
    drain();
    issue(1'b1, 0, 1'b0, 0, 1'b0, 10, 1'b1, n, ok);
    issue(1'b1, 10, 1'b0, 10, 1'b0, 2, 1'b1, n, ok);
    chk(n == 0, "R6 unused sources ignored", n, 0);
    drain();
  endtask

  task automatic t_empty_slot();
    int n; bit ok;
    issue(1'b1, 0, 1'b0, 0, 1'b0, 11, 1'b1, n, ok);
    issue(1'b0, 11, 1'b1, 11, 1'b1, 11, 1'b1, n, ok);
    chk(n == 0, "R10 empty slot no stall", n, 0);
    issue(1'b1, 11, 1'b1, 0, 1'b0, 12, 1'b1, n, ok);
    chk(n == 2, "R10 empty slot enters as non-writing", n, 2);
    drain();
  endtask

  task automatic t_chain();
    int n1, n2; bit ok;
    issue(1'b1, 0, 1'b0, 0, 1'b0, 3, 1'b1, n1, ok);
    issue(1'b1, 3, 1'b1, 0, 1'b0, 4, 1'b1, n1, ok);
    issue(1'b1, 4, 1'b1, 0, 1'b0, 5, 1'b1, n2, ok);
    chk(n1 == 3, "R3 chain first link", n1, 3);
    chk(n2 == 3, "R3 chain second link", n2, 3);
    chk(n1 <= 3 && n2 <= 3, "R9 stall run bound", (n1 > n2) ? n1 : n2, 3);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!stall && pc_we, "R1 outputs during reset", {stall, pc_we}, 2'b01);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_adjacent();
    t_distance(1, 2);
    t_distance(2, 1);
    t_distance(3, 0);
    t_two_sources();
    t_reg_zero();
    t_no_write();
    t_empty_slot();
    t_chain();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule